// File: doc/BRIEF.md
# TLB Page Invalidation Decode Checker

This block sits after instruction decode. Each cycle it may accept one decoded instruction: two opcode bytes, the ModRM byte, a LOCK prefix flag, the current privilege level, the operating mode and the effective address. If the instruction is the single-page TLB invalidate (escape byte 0x0F, group byte 0x01, ModRM reg field 7), the block applies the operand, prefix, privilege and mode rules. It then produces exactly one outcome: an invalid-opcode fault, a general-protection fault with error code zero, a silent no-op retire, or a page-invalidate request to the TLB.

The invalidate request uses a valid/ready handshake. The request carries the virtual page number, which is the effective address with the page-offset bits removed. The block accepts no new instruction while a request waits for the TLB. A one-cycle done pulse marks every retired page-invalidate instruction. Other instructions pass through without effect.

Mode encoding on `cpu_mode`: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit, 5 to 7 reserved.

Top module: `tlb_invl_gate`

## Requirements
- R1: An instruction is matched only when op_byte0 = 0x0F, op_byte1 = 0x01 and modrm[5:3] = 7. Any other instruction, or a reserved mode (5 to 7), produces no fault, no no-op, no request and no done pulse.
- R2: In real, protected or 64-bit mode, a matched instruction with modrm[7:6] = 2'b11 (register operand) raises ud_fault.
- R3: In real, protected or 64-bit mode, a matched instruction with the LOCK flag set raises ud_fault. The invalid-opcode check takes precedence over the privilege check.
- R4: In protected or 64-bit mode, a matched memory-operand instruction without LOCK and with cpl other than 0 raises gp_fault, and gp_errcode reads 0. Real mode never raises gp_fault on privilege.
- R5: In virtual-8086 mode, a matched instruction always raises gp_fault, whatever its operand, prefix or privilege.
- R6: In compatibility mode, a matched instruction never faults and always issues an invalidate request.
- R7: In 64-bit mode, an instruction that passes R2 to R4 and has a non-canonical address pulses nop_retire and issues no request. An address is canonical when bits 63 down to 47 are all equal.
- R8: The invalidate request shows inv_page = eff_addr[63:12]. inv_valid and inv_page hold steady until inv_ready is sampled high.
- R9: done pulses for one cycle in the cycle after a fault or a no-op is taken, and in the cycle after the TLB accepts a request. insn_ready is low while a request is pending.
- R10: The ud_fault, gp_fault and nop_retire pulses last one cycle. They appear in the cycle after the instruction is taken, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | A decoded instruction is presented |
| insn_ready | output | 1 | Block can take an instruction |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| lock_pfx | input | 1 | LOCK prefix present |
| cpl | input | 2 | Current privilege level |
| cpu_mode | input | 3 | Operating mode code |
| eff_addr | input | 64 | Effective address of the operand |
| ud_fault | output | 1 | Invalid-opcode fault pulse |
| gp_fault | output | 1 | General-protection fault pulse |
| gp_errcode | output | 16 | Error code for gp_fault (zero) |
| nop_retire | output | 1 | Instruction retired as a no-op |
| inv_valid | output | 1 | Page-invalidate request valid |
| inv_ready | input | 1 | TLB accepts the request |
| inv_page | output | 52 | Virtual page number to invalidate |
| done | output | 1 | Instruction retired |

## Verification
The bench targets precedence collisions: LOCK together with nonzero privilege, register operands in virtual-8086 and compatibility modes, and nonzero privilege in real mode. A wrong priority chain would report a general-protection fault where an invalid-opcode fault is due, or the reverse. Addresses one step on either side of the canonical boundary check the sign-extension test. An off-by-one in the bit range would invalidate a non-canonical page or silently drop a valid one. Requests held under a back-pressured TLB check that the page number stays fixed and that no second instruction is taken while the request waits. Near-miss opcodes (reg field 6, wrong group byte) and reserved modes must produce nothing at all.

// File: rtl/tlb_invl_pkg.sv
package tlb_invl_pkg;

   typedef enum logic [2:0] {
      MODE_REAL   = 3'd0,
      MODE_PROT   = 3'd1,
      MODE_V86    = 3'd2,
      MODE_COMPAT = 3'd3,
      MODE_LONG   = 3'd4
   } cpu_mode_e;

   typedef enum logic [2:0] {
      OUT_NONE = 3'd0,
      OUT_UD   = 3'd1,
      OUT_GP   = 3'd2,
      OUT_NOP  = 3'd3,
      OUT_INVL = 3'd4
   } outcome_e;

   localparam logic [7:0] OPC_ESCAPE = 8'h0F;
   localparam logic [7:0] OPC_GROUP  = 8'h01;
   localparam logic [2:0] REG_SELECT = 3'd7;
   localparam logic [1:0] MOD_REG    = 2'b11;

endpackage

// File: rtl/invl_canon.sv
module invl_canon #(
   parameter int VA_W    = 64,
   parameter int CANON_W = 48
) (
   input  logic [VA_W-1:0] addr,
   output logic            canon_ok
);
   localparam int HI_W = VA_W - CANON_W + 1;

   generate
      if (CANON_W > VA_W || CANON_W < 2) begin : g_bad_width
         $error("invl_canon: CANON_W must lie in 2..VA_W");
      end
      if (CANON_W == VA_W) begin : g_full
         // Every address is canonical when the full width is implemented.
         assign canon_ok = 1'b1;
      end else begin : g_sext
         logic [HI_W-1:0] hi_bits;
         assign hi_bits  = addr[VA_W-1:CANON_W-1];
         assign canon_ok = (&hi_bits) | ~(|hi_bits);
      end
   endgenerate
endmodule

// File: rtl/invl_decode.sv
module invl_decode
   import tlb_invl_pkg::*;
(
   input  logic [7:0] op_byte0,
   input  logic [7:0] op_byte1,
   input  logic [7:0] modrm,
   input  logic       lock_pfx,
   input  logic [1:0] cpl,
   input  logic [2:0] cpu_mode,
   input  logic       canon_ok,
   output logic       is_match,
   output outcome_e   outcome
);
   logic reg_operand;
   logic strict_mode;
   logic priv_mode;
   logic known_mode;

   assign is_match    = (op_byte0 == OPC_ESCAPE) && (op_byte1 == OPC_GROUP) &&
                        (modrm[5:3] == REG_SELECT);
   assign reg_operand = (modrm[7:6] == MOD_REG);
   assign known_mode  = (cpu_mode <= 3'(MODE_LONG));
   assign strict_mode = (cpu_mode == 3'(MODE_REAL)) || (cpu_mode == 3'(MODE_PROT)) ||
                        (cpu_mode == 3'(MODE_LONG));
   assign priv_mode   = (cpu_mode == 3'(MODE_PROT)) || (cpu_mode == 3'(MODE_LONG));

   // Priority chain: opcode fault, then protection fault, then canonical test.
   always_comb begin
      outcome = OUT_NONE;
      if (is_match && known_mode) begin
         if (cpu_mode == 3'(MODE_COMPAT))
            outcome = OUT_INVL;
         else if (cpu_mode == 3'(MODE_V86))
            outcome = OUT_GP;
         else if (strict_mode && (reg_operand || lock_pfx))
            outcome = OUT_UD;
         else if (priv_mode && (cpl != 2'd0))
            outcome = OUT_GP;
         else if ((cpu_mode == 3'(MODE_LONG)) && !canon_ok)
            outcome = OUT_NOP;
         else
            outcome = OUT_INVL;
      end
   end
endmodule

// File: rtl/invl_issue.sv
module invl_issue
   import tlb_invl_pkg::*;
#(
   parameter int VA_W       = 64,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       take,
   input  outcome_e                   outcome,
   input  logic [VA_W-1:0]            addr,
   input  logic                       inv_ready,
   output logic                       busy,
   output logic                       ud_fault,
   output logic                       gp_fault,
   output logic                       nop_retire,
   output logic                       inv_valid,
   output logic [VA_W-PAGE_SHIFT-1:0] inv_page,
   output logic                       done
);
   localparam int PN_W = VA_W - PAGE_SHIFT;

   generate
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= VA_W) begin : g_bad_shift
         $error("invl_issue: PAGE_SHIFT must lie in 1..VA_W-1");
      end
   endgenerate

   logic accept;
   assign accept = inv_valid && inv_ready;
   assign busy   = inv_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ud_fault   <= 1'b0;
         gp_fault   <= 1'b0;
         nop_retire <= 1'b0;
         inv_valid  <= 1'b0;
         inv_page   <= '0;
         done       <= 1'b0;
      end else begin
         ud_fault   <= 1'b0;
         gp_fault   <= 1'b0;
         nop_retire <= 1'b0;
         done       <= 1'b0;
         if (accept) begin
            inv_valid <= 1'b0;
            done      <= 1'b1;
         end
         if (take) begin
            unique case (outcome)
               OUT_UD:   begin ud_fault   <= 1'b1; done <= 1'b1; end
               OUT_GP:   begin gp_fault   <= 1'b1; done <= 1'b1; end
               OUT_NOP:  begin nop_retire <= 1'b1; done <= 1'b1; end
               OUT_INVL: begin
                  inv_valid <= 1'b1;
                  inv_page  <= addr[VA_W-1:PAGE_SHIFT];
               end
               default: ;
            endcase
         end
      end
   end

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_page)));

   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ud_fault, gp_fault, nop_retire}));

   assert_fault_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ud_fault || gp_fault || nop_retire) |-> done);

   assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_ready) |=> (done && !inv_valid));

   assert_req_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(inv_valid && done));

   logic [PN_W-1:0] unused_pn;
   assign unused_pn = '0;
endmodule

// File: rtl/tlb_invl_gate.sv
module tlb_invl_gate
   import tlb_invl_pkg::*;
#(
   parameter int VA_W       = 64,
   parameter int CANON_W    = 48,
   parameter int PAGE_SHIFT = 12,
   parameter int ERR_W      = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       insn_valid,
   output logic                       insn_ready,
   input  logic [7:0]                 op_byte0,
   input  logic [7:0]                 op_byte1,
   input  logic [7:0]                 modrm,
   input  logic                       lock_pfx,
   input  logic [1:0]                 cpl,
   input  logic [2:0]                 cpu_mode,
   input  logic [VA_W-1:0]            eff_addr,
   output logic                       ud_fault,
   output logic                       gp_fault,
   output logic [ERR_W-1:0]           gp_errcode,
   output logic                       nop_retire,
   output logic                       inv_valid,
   input  logic                       inv_ready,
   output logic [VA_W-PAGE_SHIFT-1:0] inv_page,
   output logic                       done
);
   generate
      if (ERR_W < 1) begin : g_bad_err
         $error("tlb_invl_gate: ERR_W must be positive");
      end
   endgenerate

   logic     canon_ok;
   logic     is_match;
   logic     busy;
   logic     take;
   outcome_e outcome;

   invl_canon #(.VA_W(VA_W), .CANON_W(CANON_W)) u_canon (
      .addr     (eff_addr),
      .canon_ok (canon_ok)
   );

   invl_decode u_decode (
      .op_byte0 (op_byte0),
      .op_byte1 (op_byte1),
      .modrm    (modrm),
      .lock_pfx (lock_pfx),
      .cpl      (cpl),
      .cpu_mode (cpu_mode),
      .canon_ok (canon_ok),
      .is_match (is_match),
      .outcome  (outcome)
   );

   assign insn_ready = !busy;
   assign take       = insn_valid && insn_ready;
   assign gp_errcode = '0;

   invl_issue #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_issue (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .outcome    (outcome),
      .addr       (eff_addr),
      .inv_ready  (inv_ready),
      .busy       (busy),
      .ud_fault   (ud_fault),
      .gp_fault   (gp_fault),
      .nop_retire (nop_retire),
      .inv_valid  (inv_valid),
      .inv_page   (inv_page),
      .done       (done)
   );

   assert_v86_gp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_match && (cpu_mode == 3'(MODE_V86))) |=> gp_fault);

   assert_nomatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !is_match) |=> !(ud_fault || gp_fault || nop_retire || $rose(inv_valid)));

   assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !insn_ready);
endmodule

// File: tb/tb_tlb_invl_gate.sv
module tb_tlb_invl_gate;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        insn_valid;
   logic        insn_ready;
   logic [7:0]  op_byte0, op_byte1, modrm;
   logic        lock_pfx;
   logic [1:0]  cpl;
   logic [2:0]  cpu_mode;
   logic [63:0] eff_addr;
   logic        ud_fault, gp_fault, nop_retire, inv_valid, inv_ready, done;
   logic [15:0] gp_errcode;
   logic [51:0] inv_page;

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   tlb_invl_gate dut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
      .op_byte0(op_byte0), .op_byte1(op_byte1), .modrm(modrm), .lock_pfx(lock_pfx),
      .cpl(cpl), .cpu_mode(cpu_mode), .eff_addr(eff_addr),
      .ud_fault(ud_fault), .gp_fault(gp_fault), .gp_errcode(gp_errcode),
      .nop_retire(nop_retire), .inv_valid(inv_valid), .inv_ready(inv_ready),
      .inv_page(inv_page), .done(done)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
         miscompares = miscompares + 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   // 0 none, 1 invalid opcode, 2 protection, 3 no-op, 4 invalidate
   function automatic int exp_outcome(logic [7:0] b0, logic [7:0] b1, logic [7:0] m,
                                      logic lk, logic [1:0] pl, logic [2:0] md,
                                      logic [63:0] a);
      logic canon;
      canon = (a == {{16{a[47]}}, a[47:0]});
      if (!(b0 == 8'h0F && b1 == 8'h01 && m[5:3] == 3'd7) || md > 3'd4) return 0;
      if (md == 3'd3) return 4;
      if (md == 3'd2) return 2;
      if (m[7:6] == 2'b11 || lk) return 1;
      if ((md == 3'd1 || md == 3'd4) && pl != 2'd0) return 2;
      if (md == 3'd4 && !canon) return 3;
      return 4;
   endfunction

   function automatic string req_tag(int e, logic [7:0] m, logic [2:0] md);
      case (e)
         1: return (m[7:6] == 2'b11) ? "R2" : "R3";
         2: return (md == 3'd2) ? "R5" : "R4";
         3: return "R7";
         4: return (md == 3'd3) ? "R6" : "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      vectors = vectors + 1;
      if (act !== exp) begin
         miscompares = miscompares + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Starts and ends at a negedge.
   task automatic run_insn(logic [7:0] b0, logic [7:0] b1, logic [7:0] m, logic lk,
                           logic [1:0] pl, logic [2:0] md, logic [63:0] a, int stall);
      int e;
      string t;
      e = exp_outcome(b0, b1, m, lk, pl, md, a);
      t = req_tag(e, m, md);
      check("R9", "insn_ready idle", 64'(insn_ready), 64'd1);
      op_byte0 = b0; op_byte1 = b1; modrm = m; lock_pfx = lk; cpl = pl;
      cpu_mode = md; eff_addr = a; insn_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      insn_valid = 1'b0;
      check(t, "ud_fault",   64'(ud_fault),   64'(e == 1));
      check(t, "gp_fault",   64'(gp_fault),   64'(e == 2));
      check(t, "nop_retire", 64'(nop_retire), 64'(e == 3));
      check(t, "inv_valid",  64'(inv_valid),  64'(e == 4));
      check("R10", "done after take", 64'(done), 64'(e == 1 || e == 2 || e == 3));
      if (e == 2) check("R4", "gp_errcode", 64'(gp_errcode), 64'd0);
      if (e == 4) begin
         check("R8", "inv_page", 64'(inv_page), 64'(a[63:12]));
         for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check("R8", "held valid", 64'(inv_valid), 64'd1);
            check("R8", "held page", 64'(inv_page), 64'(a[63:12]));
            check("R9", "busy not ready", 64'(insn_ready), 64'd0);
            check("R9", "no done while pending", 64'(done), 64'd0);
         end
         inv_ready = 1'b1;
         @(negedge clk);
         inv_ready = 1'b0;
         check("R9", "done on accept", 64'(done), 64'd1);
         check("R8", "request dropped", 64'(inv_valid), 64'd0);
      end
      @(negedge clk);
      check("R10", "pulses cleared", 64'({ud_fault, gp_fault, nop_retire, done}), 64'd0);
   endtask

   initial begin
      logic [63:0] a;
      logic [7:0]  b0, b1, m;
      rst_n = 1'b0; insn_valid = 1'b0; inv_ready = 1'b0;
      op_byte0 = '0; op_byte1 = '0; modrm = '0; lock_pfx = 1'b0; cpl = '0;
      cpu_mode = '0; eff_addr = '0;
      void'($urandom(32'h1A5E_ED01));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R10", "reset outputs",
            64'({ud_fault, gp_fault, nop_retire, inv_valid, done}), 64'd0);
      check("R9", "reset ready", 64'(insn_ready), 64'd1);

      // Directed corners
      run_insn(8'h0F, 8'h01, 8'h38, 1'b0, 2'd0, 3'd1, 64'h0000_1234_5678_9ABC, 2); // R8
      run_insn(8'h0F, 8'h01, 8'h30, 1'b0, 2'd0, 3'd1, 64'h1000, 0);                // R1 reg 6
      run_insn(8'h0F, 8'h02, 8'h38, 1'b0, 2'd0, 3'd1, 64'h1000, 0);                // R1 group
      run_insn(8'h0F, 8'h01, 8'hF8, 1'b0, 2'd0, 3'd0, 64'h1000, 0);                // R2 real
      run_insn(8'h0F, 8'h01, 8'h38, 1'b1, 2'd3, 3'd1, 64'h1000, 0);                // R3 over R4
      run_insn(8'h0F, 8'h01, 8'h78, 1'b0, 2'd3, 3'd4, 64'h1000, 0);                // R4
      run_insn(8'h0F, 8'h01, 8'h38, 1'b0, 2'd3, 3'd0, 64'h5000, 0);                // R4 real ok
      run_insn(8'h0F, 8'h01, 8'hF8, 1'b1, 2'd0, 3'd2, 64'h1000, 0);                // R5
      run_insn(8'h0F, 8'h01, 8'hF8, 1'b1, 2'd3, 3'd3, 64'hFFFF_0000_0000_0000, 1); // R6
      run_insn(8'h0F, 8'h01, 8'hB8, 1'b0, 2'd0, 3'd4, 64'h0000_7FFF_FFFF_F000, 1); // R7 edge
      run_insn(8'h0F, 8'h01, 8'hB8, 1'b0, 2'd0, 3'd4, 64'h0000_8000_0000_0000, 0); // R7
      run_insn(8'h0F, 8'h01, 8'hB8, 1'b0, 2'd0, 3'd4, 64'hFFFF_8000_0000_0000, 0); // R7
      run_insn(8'h0F, 8'h01, 8'hB8, 1'b0, 2'd0, 3'd4, 64'hFFFF_7FFF_FFFF_FFFF, 0); // R7
      run_insn(8'h0F, 8'h01, 8'h38, 1'b0, 2'd0, 3'd5, 64'h1000, 0);                // R1 reserved

      // Constrained random
      for (int i = 0; i < 2500; i++) begin
         b0 = ($urandom_range(0, 9) < 8) ? 8'h0F : 8'($urandom);
         b1 = ($urandom_range(0, 9) < 8) ? 8'h01 : 8'($urandom);
         m  = 8'($urandom);
         if ($urandom_range(0, 3) != 0) m[5:3] = 3'd7;
         a  = {$urandom, $urandom};
         if ($urandom_range(0, 1) == 0) a = {{16{a[47]}}, a[47:0]};
         run_insn(b0, b1, m, ($urandom_range(0, 4) == 0), 2'($urandom),
                  3'($urandom_range(0, 5)), a, $urandom_range(0, 3));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule